// File: doc/BRIEF.md
# Grouped Programmable Interrupt Prioritizer

This block resolves which of six interrupt requests is to be served next. Requests are held in a pending register. Single-cycle hardware pulses set bits in that register, and software can load it directly over a small byte bus. A mask register holds one enable per request and a global enable. The block reports a valid flag and the 3-bit index of the winning unmasked request. An acknowledge strobe retires that one request.

Priority works on two levels. The six requests form three fixed pairs: pair A holds requests 3 and 5, pair B holds 0 and 2, and pair C holds 1 and 4. A write-only priority register sets the order of the three pairs and, for each pair, which member goes first.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the pending register, the mask register and the priority register are zero. `valid_o` is low and every readable address returns 0.
- R2: The priority register is at address 0 and is write-only; reads of address 0 return 0. Its bits 7 and 6 have no effect on resolution.
- R3: The pending register is at address 1 and can be read and written. Bit n holds request n for n = 0 to 5, and bits 7 and 6 read as 0.
- R4: A high bit on `irq_pulse_i` sets the matching pending bit at the next clock edge. Bit 3 of `irq_pulse_i` is ignored, so request 3 can only be set by software.
- R5: If a hardware pulse and a software write of 0 (or an acknowledge) hit the same pending bit in the same cycle, the bit ends up set.
- R6: The mask register is at address 2. Bit 7 is the global enable, bits 5 to 0 enable requests 5 to 0, and bit 6 reads as 0.
- R7: `valid_o` is high only when the global enable is 1, at least one pending bit has its enable set, and the pair-order code is not reserved. `index_o` is 0 whenever `valid_o` is low. Both outputs follow the register state in the same cycle.
- R8: The pair-order code is formed as {priority bit 4, bit 3, bit 0}. The codes 000 and 111 are reserved and force `valid_o` low.
- R9: Priority bit 1 orders pair C (0: request 1 first, 1: request 4 first). Bit 2 orders pair B (0: request 2 first, 1: request 0 first). Bit 5 orders pair A (0: request 5 first, 1: request 3 first).
- R10: The pair order for each code is: 001 gives C, A, B; 010 gives A, B, C; 011 gives A, C, B; 100 gives B, C, A; 101 gives C, B, A; 110 gives B, A, C. The winner is the first member, in that order, that is pending and enabled.
- R11: While `valid_o` is high, `ack_i` clears only the pending bit named by `index_o`. While `valid_o` is low, `ack_i` changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 2 | Register address (0 priority, 1 pending, 2 mask) |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i`, combinational |
| irq_pulse_i | input | 6 | Hardware request pulses, one bit per request |
| ack_i | input | 1 | Acknowledge of the current winner |
| valid_o | output | 1 | A request is selected |
| index_o | output | 3 | Index of the selected request |

## Verification
Assertions check on every cycle that a valid winner is pending, enabled and under the global enable. They also check that a reserved code never yields a winner, that a hardware pulse always lands in the pending register, and that an acknowledged winner is gone on the next cycle. Whether the chosen index is the right one depends on the full two-level ordering. Only the bench's sweep can show this: it covers every pair-order code, every swap combination, every pending pattern and several mask patterns against an arithmetic model. The order in which a full set of requests is served under acknowledges, and the behaviour of the readback fields, are likewise shown only by directed scenarios.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int unsigned NUM_IRQ = 6;
  localparam int unsigned IDX_W   = 3;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned NUM_GRP = 3;

  localparam logic [ADDR_W-1:0] ADDR_PRIO = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_REQ  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 2'd2;

  typedef enum logic [1:0] {GRP_A = 2'd0, GRP_B = 2'd1, GRP_C = 2'd2} grp_e;

  typedef struct packed {
    logic ok;
    grp_e g0;
    grp_e g1;
    grp_e g2;
  } grp_order_t;

  function automatic grp_order_t decode_order(input logic [2:0] code);
    grp_order_t o;
    o = '{ok: 1'b1, g0: GRP_A, g1: GRP_B, g2: GRP_C};
    unique case (code)
      3'b001: begin o.g0 = GRP_C; o.g1 = GRP_A; o.g2 = GRP_B; end
      3'b010: begin o.g0 = GRP_A; o.g1 = GRP_B; o.g2 = GRP_C; end
      3'b011: begin o.g0 = GRP_A; o.g1 = GRP_C; o.g2 = GRP_B; end
      3'b100: begin o.g0 = GRP_B; o.g1 = GRP_C; o.g2 = GRP_A; end
      3'b101: begin o.g0 = GRP_C; o.g1 = GRP_B; o.g2 = GRP_A; end
      3'b110: begin o.g0 = GRP_B; o.g1 = GRP_A; o.g2 = GRP_C; end
      default: o.ok = 1'b0;
    endcase
    return o;
  endfunction

  function automatic logic [2:0] order_code(input logic [DATA_W-1:0] prio);
    return {prio[4], prio[3], prio[0]};
  endfunction
endpackage

// File: rtl/irq_req_regs.sv
module irq_req_regs
  import irq_prio_pkg::*;
#(
  parameter int unsigned        N_IRQ = NUM_IRQ,
  parameter int unsigned        DW    = DATA_W,
  parameter int unsigned        AW    = ADDR_W,
  parameter logic [N_IRQ-1:0]   HW_SRC = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic             we_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [N_IRQ-1:0] hw_set_i,
  input  logic [N_IRQ-1:0] clr_i,
  output logic [DW-1:0]    prio_o,
  output logic [N_IRQ-1:0] req_o,
  output logic [N_IRQ-1:0] en_o,
  output logic             gie_o
);
  localparam int unsigned GIE_BIT = DW - 1;
  localparam int unsigned PAD_W   = DW - N_IRQ;

  logic [DW-1:0]    prio_q;
  logic [N_IRQ-1:0] req_q, req_d, req_base, hw_set;
  logic [N_IRQ-1:0] en_q;
  logic             gie_q;
  logic             wr_prio, wr_req, wr_mask;

  assign wr_prio = we_i && (addr_i == ADDR_PRIO);
  assign wr_req  = we_i && (addr_i == ADDR_REQ);
  assign wr_mask = we_i && (addr_i == ADDR_MASK);
  assign hw_set  = hw_set_i & HW_SRC;

  // software load and ack first, hardware set last so it wins
  always_comb begin
    req_base = wr_req ? wdata_i[N_IRQ-1:0] : req_q;
    req_base = req_base & ~clr_i;
    req_d    = req_base | hw_set;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q <= '0;
      req_q  <= '0;
      en_q   <= '0;
      gie_q  <= 1'b0;
    end else begin
      req_q <= req_d;
      if (wr_prio) prio_q <= wdata_i;
      if (wr_mask) begin
        en_q  <= wdata_i[N_IRQ-1:0];
        gie_q <= wdata_i[GIE_BIT];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_REQ:  rdata_o = {{PAD_W{1'b0}}, req_q};
      ADDR_MASK: begin
        rdata_o[N_IRQ-1:0] = en_q;
        rdata_o[GIE_BIT]   = gie_q;
      end
      default:   rdata_o = '0;
    endcase
  end

  assign prio_o = prio_q;
  assign req_o  = req_q;
  assign en_o   = en_q;
  assign gie_o  = gie_q;

  p_hw_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hw_set) |=> ((req_q & $past(hw_set)) == $past(hw_set)));

  p_upper_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_REQ) |-> (rdata_o[DW-1:N_IRQ] == '0));
endmodule

// File: rtl/irq_pair_pick.sv
module irq_pair_pick
  import irq_prio_pkg::*;
#(
  parameter int unsigned N_IRQ   = NUM_IRQ,
  parameter int unsigned IW      = IDX_W,
  parameter int unsigned FIRST   = 0,
  parameter int unsigned SECOND  = 1
) (
  input  logic [N_IRQ-1:0] pend_i,
  input  logic             swap_i,
  output logic             hit_o,
  output logic [IW-1:0]    idx_o
);
  localparam logic [IW-1:0] FIRST_IDX  = IW'(FIRST);
  localparam logic [IW-1:0] SECOND_IDX = IW'(SECOND);

  logic          lead_p, tail_p;
  logic [IW-1:0] lead_i, tail_i;

  always_comb begin
    if (swap_i) begin
      lead_p = pend_i[SECOND]; lead_i = SECOND_IDX;
      tail_p = pend_i[FIRST];  tail_i = FIRST_IDX;
    end else begin
      lead_p = pend_i[FIRST];  lead_i = FIRST_IDX;
      tail_p = pend_i[SECOND]; tail_i = SECOND_IDX;
    end
    hit_o = lead_p | tail_p;
    idx_o = lead_p ? lead_i : tail_i;
  end
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
  import irq_prio_pkg::*;
#(
  parameter int unsigned N_IRQ = NUM_IRQ,
  parameter int unsigned IW    = IDX_W,
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned NG    = NUM_GRP
) (
  input  logic [N_IRQ-1:0] pend_i,
  input  logic [DW-1:0]    prio_i,
  output logic             valid_o,
  output logic [IW-1:0]    index_o
);
  // index by grp_e: A, B, C
  localparam int unsigned FIRST_T  [NG] = '{5, 2, 1};
  localparam int unsigned SECOND_T [NG] = '{3, 0, 4};
  localparam int unsigned SWAP_T   [NG] = '{5, 2, 1};

  logic [NG-1:0]        hit;
  logic [NG-1:0][IW-1:0] gidx;
  grp_order_t           ord;

  for (genvar g = 0; g < NG; g++) begin : g_pair
    irq_pair_pick #(
      .N_IRQ (N_IRQ),
      .IW    (IW),
      .FIRST (FIRST_T[g]),
      .SECOND(SECOND_T[g])
    ) u_pick (
      .pend_i(pend_i),
      .swap_i(prio_i[SWAP_T[g]]),
      .hit_o (hit[g]),
      .idx_o (gidx[g])
    );
  end

  assign ord = decode_order(order_code(prio_i));

  always_comb begin
    valid_o = ord.ok && (|hit);
    index_o = '0;
    if (valid_o) begin
      if (hit[ord.g0])      index_o = gidx[ord.g0];
      else if (hit[ord.g1]) index_o = gidx[ord.g1];
      else                  index_o = gidx[ord.g2];
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int unsigned N_IRQ = NUM_IRQ,
  parameter int unsigned IW    = IDX_W,
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned AW    = ADDR_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic             bus_we_i,
  input  logic [DW-1:0]    bus_wdata_i,
  output logic [DW-1:0]    bus_rdata_o,
  input  logic [N_IRQ-1:0] irq_pulse_i,
  input  logic             ack_i,
  output logic             valid_o,
  output logic [IW-1:0]    index_o
);
  // request 3 has no hardware source
  localparam logic [N_IRQ-1:0] HW_SRC = ~(N_IRQ'(1) << 3);

  logic [DW-1:0]    prio;
  logic [N_IRQ-1:0] req, en, pend, clr;
  logic             gie, win_valid;
  logic [IW-1:0]    win_idx;

  irq_req_regs #(
    .N_IRQ (N_IRQ),
    .DW    (DW),
    .AW    (AW),
    .HW_SRC(HW_SRC)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (bus_addr_i),
    .we_i    (bus_we_i),
    .wdata_i (bus_wdata_i),
    .rdata_o (bus_rdata_o),
    .hw_set_i(irq_pulse_i),
    .clr_i   (clr),
    .prio_o  (prio),
    .req_o   (req),
    .en_o    (en),
    .gie_o   (gie)
  );

  assign pend = gie ? (req & en) : '0;

  irq_resolver #(
    .N_IRQ(N_IRQ),
    .IW   (IW),
    .DW   (DW)
  ) u_res (
    .pend_i (pend),
    .prio_i (prio),
    .valid_o(win_valid),
    .index_o(win_idx)
  );

  assign valid_o = win_valid;
  assign index_o = win_idx;
  assign clr     = (ack_i && win_valid) ? (N_IRQ'(1) << win_idx) : '0;

  p_valid_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (gie && ((req & en) != '0)));

  p_reserved_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((order_code(prio) == 3'b000) || (order_code(prio) == 3'b111)) |-> !valid_o);

  p_winner_pending_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (req[index_o] && en[index_o]));

  p_ack_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && valid_o && !(bus_we_i && bus_addr_i == ADDR_REQ) && !irq_pulse_i[index_o])
      |=> !req[$past(index_o)]);
endmodule

// File: tb/irq_prio_ctrl_bench.sv
`timescale 1ns/1ps
module irq_prio_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [5:0] pulse = '0;
  logic       ack = 1'b0;
  logic       valid;
  logic [2:0] index;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_pulse_i(pulse),
    .ack_i(ack), .valid_o(valid), .index_o(index)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic logic [7:0] prio_byte(input logic [2:0] code, input logic sa,
                                           input logic sb, input logic sc);
    return {2'b11, sa, code[2], code[1], sb, sc, code[0]};
  endfunction

  // model: returns {valid, idx}
  function automatic logic [3:0] model(input logic [2:0] code, input logic sa,
      input logic sb, input logic sc, input logic [5:0] pend);
    int grp[3];
    int seq[6];
    case (code)
      3'd1: grp = '{2, 0, 1};
      3'd2: grp = '{0, 1, 2};
      3'd3: grp = '{0, 2, 1};
      3'd4: grp = '{1, 2, 0};
      3'd5: grp = '{2, 1, 0};
      3'd6: grp = '{1, 0, 2};
      default: return 4'b0000;
    endcase
    for (int k = 0; k < 3; k++) begin
      case (grp[k])
        0: begin seq[2*k] = sa ? 3 : 5; seq[2*k+1] = sa ? 5 : 3; end
        1: begin seq[2*k] = sb ? 0 : 2; seq[2*k+1] = sb ? 2 : 0; end
        default: begin seq[2*k] = sc ? 4 : 1; seq[2*k+1] = sc ? 1 : 4; end
      endcase
    end
    for (int k = 0; k < 6; k++)
      if (pend[seq[k]]) return {1'b1, 3'(seq[k])};
    return 4'b0000;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] masks [4] = '{8'hBF, 8'h95, 8'hAA, 8'h3F};
    logic [3:0] exp;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid", valid, 0);
    rd(2'd0, d); chk("R1 prio read", d, 0);
    rd(2'd1, d); chk("R1 req read", d, 0);
    rd(2'd2, d); chk("R1 mask read", d, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 write-only priority, R3 req readback, R6 mask readback
    wr(2'd0, 8'hFF); rd(2'd0, d); chk("R2 prio reads zero", d, 0);
    wr(2'd1, 8'hFF); rd(2'd1, d); chk("R3 req upper bits", d, 8'h3F);
    wr(2'd1, 8'h05); rd(2'd1, d); chk("R3 req load", d, 8'h05);
    wr(2'd2, 8'hFF); rd(2'd2, d); chk("R6 mask bit6 zero", d, 8'hBF);
    // R8 reserved code 111 with pending, enabled
    chk("R8 code 111 no valid", valid, 0);
    wr(2'd0, prio_byte(3'b000, 0, 0, 0));
    chk("R8 code 000 no valid", valid, 0);

    // R4 hardware pulses, request 3 ignored
    wr(2'd1, 8'h00);
    @(negedge clk); pulse = 6'h3F;
    @(negedge clk); pulse = 6'h00;
    rd(2'd1, d); chk("R4 pulse sets, bit3 ignored", d, 8'h37);
    // R5 set beats software clear
    @(negedge clk); addr = 2'd1; wdata = 8'h00; we = 1'b1; pulse = 6'h01;
    @(negedge clk); we = 1'b0; pulse = 6'h00;
    rd(2'd1, d); chk("R5 set wins over write", d, 8'h01);

    // R11 ack order under code 010, no swaps: 5,3,2,0,1,4
    begin
      int order[6] = '{5, 3, 2, 0, 1, 4};
      logic [5:0] left = 6'h3F;
      wr(2'd0, prio_byte(3'b010, 0, 0, 0));
      wr(2'd1, 8'h3F);
      wr(2'd2, 8'hBF);
      for (int k = 0; k < 6; k++) begin
        chk("R11 ack seq valid", valid, 1);
        chk("R11 ack seq index", index, order[k]);
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        left[order[k]] = 1'b0;
        rd(2'd1, d); chk("R11 only winner cleared", d, {2'b00, left});
      end
      chk("R11 drained", valid, 0);
    end
    // R11 ack ignored when valid low (global enable off)
    wr(2'd1, 8'h3F);
    wr(2'd2, 8'h3F);
    chk("R7 gie off", valid, 0);
    chk("R7 index zero when idle", index, 0);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    rd(2'd1, d); chk("R11 ack without valid", d, 8'h3F);
    // R5 hardware set beats ack on same bit
    wr(2'd2, 8'hBF);
    @(negedge clk); ack = 1'b1; pulse = 6'h01 << index;
    @(negedge clk); ack = 1'b0; pulse = 6'h00;
    rd(2'd1, d); chk("R5 set wins over ack", d, 8'h3F);

    // R7 R8 R9 R10 sweep
    for (int code = 0; code < 8; code++) begin
      for (int sw = 0; sw < 8; sw++) begin
        wr(2'd0, prio_byte(3'(code), sw[2], sw[1], sw[0]));
        for (int m = 0; m < 4; m++) begin
          wr(2'd2, masks[m]);
          for (int p = 1; p < 64; p++) begin
            wr(2'd1, 8'(p));
            exp = masks[m][7] ? model(3'(code), sw[2], sw[1], sw[0], 6'(p) & masks[m][5:0])
                              : 4'b0000;
            chk("R10 R9 R8 R7 sweep valid", valid, exp[3]);
            chk("R10 R9 R7 sweep index", index, exp[2:0]);
          end
        end
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule